// File: doc/BRIEF.md
# Clock Alignment Lock Detector

This block decides whether a feedback clock is phase-aligned with a reference clock. Both clocks are plain inputs that are sampled in a faster system clock domain. Each input passes through a synchronizer and a rising-edge detector. On every reference rising edge, the block measures how many system ticks separate that edge from the nearest feedback rising edge. It then compares that distance with a programmable window and produces one aligned or misaligned sample per reference cycle.

A control state machine turns the stream of samples into a lock indication with hysteresis. An unbroken run of aligned samples of a programmable length raises `locked`. Once locked, only an unbroken run of misaligned samples of a second programmable length clears it. An enable input parks the whole block. An optional start gate keeps the acquisition from starting until an external signal arrives. A two-bit phase output reports the state the detector is in.

Top module: `clk_align_lock`

## Requirements
- R1: A reference rising edge counts as aligned when a feedback rising edge lies at most `windowSet` system ticks before or after it, measured on the synchronized edges and inclusive of the limit. With `windowSet` = 0, the two edges must arrive in the same tick.
- R2: In the acquire phase, `locked` rises on the `lockCount`-th consecutive aligned sample. Any misaligned sample restarts the run from zero.
- R3: In the locked phase, `locked` falls and the phase returns to acquire on the `unlockCount`-th consecutive misaligned sample. Any aligned sample restarts that run from zero.
- R4: A `lockCount` or `unlockCount` of zero behaves as one, so a single qualifying sample is enough.
- R5: While `enable` is low, `locked` is low in the same cycle and the phase is idle. Both runs are cleared, so after re-enable a full `lockCount` of aligned samples is needed again.
- R6: With `gateWaitEn` high, the detector leaves idle for the gate phase. It stays there, ignoring samples, until `startGate` is seen high, and then moves to acquire.
- R7: `phase` encodes 0 = idle, 1 = waiting for the start gate, 2 = acquiring, 3 = locked. Idle never goes directly to locked.
- R8: While `rstN` is low, `locked` is 0 and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the detector when high |
| gateWaitEn | input | 1 | Hold acquisition until the start gate is seen |
| startGate | input | 1 | External start signal |
| refClkIn | input | 1 | Reference clock, asynchronous |
| fbClkIn | input | 1 | Feedback clock, asynchronous |
| windowSet | input | 5 | Alignment window in system ticks |
| lockCount | input | 10 | Aligned samples needed to lock |
| unlockCount | input | 10 | Misaligned samples needed to unlock |
| locked | output | 1 | Lock indication |
| phase | output | 2 | Current detector phase |

## Verification
The feedback clock is driven as a delayed copy of the reference. Some offsets lag the reference and others lead it. Offsets are placed exactly on the window limit and one tick beyond it, so that the before-edge and after-edge measurements are each exercised and the inclusive limit is distinguished from an exclusive one. Runs are ended one sample short of and exactly at the programmed counts, which separates an off-by-one count from a correct one. Interrupting a misaligned run with one aligned cycle shows whether the unlock run really restarts. Stopping the feedback clock altogether produces a clean stream of misaligned samples.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GATE = 2'd1,
    PH_ACQ  = 2'd2,
    PH_LOCK = 2'd3
  } phase_e;

  // One sample per reference cycle, produced by the datapath
  typedef struct packed {
    logic valid;
    logic aligned;
  } sample_t;

  // Strobes from control to the datapath run counters
  typedef struct packed {
    logic runClr;
    logic lockInc;
    logic lockClr;
    logic missInc;
    logic missClr;
  } ctrl_t;

endpackage

// File: rtl/cal_edge_sync.sv
module cal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], din};
  end

  // chain[STAGES-1] is the last synchronizer flop, chain[STAGES] its history
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int WIN_W       = 5,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic             fbClkIn,
  input  logic [WIN_W-1:0] windowSet,
  input  logic [CNT_W-1:0] lockCount,
  input  logic [CNT_W-1:0] unlockCount,
  input  ctrl_t            ctrl,
  output sample_t          sample,
  output logic             lockHit,
  output logic             missHit
);
  localparam int DIST_W = WIN_W + 1;   // saturates above any window value

  logic refRise, fbRise;

  cal_edge_sync #(.STAGES(SYNC_STAGES)) u_refSync (
    .clk(clk), .rstN(rstN), .din(refClkIn), .rise(refRise)
  );
  cal_edge_sync #(.STAGES(SYNC_STAGES)) u_fbSync (
    .clk(clk), .rstN(rstN), .din(fbClkIn), .rise(fbRise)
  );

  logic [DIST_W-1:0] sinceFb;
  logic [DIST_W-1:0] afterCnt;
  logic [DIST_W-1:0] winExt;
  logic              pending;
  logic              beforeOk;
  logic              startPending;

  assign winExt   = {1'b0, windowSet};
  // distance to previous feedback edge is sinceFb + 1 unless coincident
  assign beforeOk = fbRise || (sinceFb < winExt);
  assign startPending = refRise && !beforeOk && (windowSet != '0);

  always_comb begin
    sample = '0;
    if (pending) begin
      if (fbRise) begin
        sample.valid   = 1'b1;
        sample.aligned = 1'b1;
      end else if (afterCnt >= winExt) begin
        sample.valid   = 1'b1;
        sample.aligned = 1'b0;
      end
    end
    if (refRise) begin
      if (beforeOk) begin
        sample.valid   = 1'b1;
        sample.aligned = 1'b1;
      end else if (windowSet == '0) begin
        sample.valid   = 1'b1;
        sample.aligned = 1'b0;
      end else begin
        sample.valid   = 1'b0;
        sample.aligned = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceFb  <= '1;
      afterCnt <= '0;
      pending  <= 1'b0;
    end else begin
      if (fbRise)              sinceFb <= '0;
      else if (sinceFb != '1)  sinceFb <= sinceFb + 1'b1;

      if (startPending) begin
        pending  <= 1'b1;
        afterCnt <= {{(DIST_W-1){1'b0}}, 1'b1};
      end else if (pending) begin
        if (sample.valid) pending <= 1'b0;
        afterCnt <= afterCnt + 1'b1;
      end
    end
  end

  // Run counters with zero-as-one targets
  logic [CNT_W-1:0] lockRun, missRun;
  logic [CNT_W-1:0] effLock, effMiss;

  assign effLock = (lockCount   == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : lockCount;
  assign effMiss = (unlockCount == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : unlockCount;
  assign lockHit = lockRun >= (effLock - 1'b1);
  assign missHit = missRun >= (effMiss - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockRun <= '0;
      missRun <= '0;
    end else if (ctrl.runClr) begin
      lockRun <= '0;
      missRun <= '0;
    end else begin
      if (ctrl.lockClr)      lockRun <= '0;
      else if (ctrl.lockInc) lockRun <= lockRun + 1'b1;
      if (ctrl.missClr)      missRun <= '0;
      else if (ctrl.missInc) missRun <= missRun + 1'b1;
    end
  end
endmodule

// File: rtl/cal_control.sv
module cal_control
  import cal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    gateWaitEn,
  input  logic    startGate,
  input  sample_t sample,
  input  logic    lockHit,
  input  logic    missHit,
  output ctrl_t   ctrl,
  output phase_e  state
);
  phase_e nextState;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    if (!enable) begin
      nextState   = PH_IDLE;
      ctrl.runClr = 1'b1;
    end else begin
      case (state)
        PH_IDLE: begin
          ctrl.runClr = 1'b1;
          nextState   = gateWaitEn ? PH_GATE : PH_ACQ;
        end
        PH_GATE: begin
          ctrl.runClr = 1'b1;
          if (startGate) nextState = PH_ACQ;
        end
        PH_ACQ: begin
          if (sample.valid) begin
            if (!sample.aligned) begin
              ctrl.lockClr = 1'b1;
            end else if (lockHit) begin
              nextState   = PH_LOCK;
              ctrl.runClr = 1'b1;
            end else begin
              ctrl.lockInc = 1'b1;
            end
          end
        end
        PH_LOCK: begin
          if (sample.valid) begin
            if (sample.aligned) begin
              ctrl.missClr = 1'b1;
            end else if (missHit) begin
              nextState   = PH_ACQ;
              ctrl.runClr = 1'b1;
            end else begin
              ctrl.missInc = 1'b1;
            end
          end
        end
        default: nextState = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/clk_align_lock.sv
module clk_align_lock
  import cal_pkg::*;
#(
  parameter int WIN_W       = 5,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             gateWaitEn,
  input  logic             startGate,
  input  logic             refClkIn,
  input  logic             fbClkIn,
  input  logic [WIN_W-1:0] windowSet,
  input  logic [CNT_W-1:0] lockCount,
  input  logic [CNT_W-1:0] unlockCount,
  output logic             locked,
  output logic [1:0]       phase
);
  sample_t sample;
  ctrl_t   ctrl;
  logic    lockHit, missHit;
  phase_e  state;

  cal_datapath #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .refClkIn(refClkIn), .fbClkIn(fbClkIn),
    .windowSet(windowSet), .lockCount(lockCount), .unlockCount(unlockCount),
    .ctrl(ctrl), .sample(sample), .lockHit(lockHit), .missHit(missHit)
  );

  cal_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .gateWaitEn(gateWaitEn),
    .startGate(startGate), .sample(sample), .lockHit(lockHit),
    .missHit(missHit), .ctrl(ctrl), .state(state)
  );

  assign locked = (state == PH_LOCK) && enable;
  assign phase  = state;
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       gateWaitEn,
  input logic       startGate,
  input logic       locked,
  input logic [1:0] phase
);
  p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !locked);

  p_lock_from_acq_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(phase) == 2'd2);

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == 2'd1 && !startGate) |=> phase == 2'd1);

  p_idle_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd0 && enable) |=> phase == (gateWaitEn ? 2'd1 : 2'd2) || phase == 2'd0);

  p_unlock_to_acq_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == 2'd3 && $past(enable) && phase != 2'd3) |-> phase == 2'd2);
endmodule

bind clk_align_lock cal_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .gateWaitEn(gateWaitEn),
  .startGate(startGate), .locked(locked), .phase(phase)
);

// File: tb/sim_clk_align_lock.sv
module sim_clk_align_lock;
  localparam int CLK_PERIOD = 10;
  localparam int REF_P      = 64;

  typedef struct packed {
    logic [6:0] off;
    logic [4:0] win;
    logic [9:0] lockC;
    logic [7:0] periods;
    logic       expLock;
  } row_t;

  // R1/R2/R4 patterns: lag offsets, lead offsets, window limits, counts
  localparam row_t ROWS [11] = '{
    '{7'd3,  5'd6,  10'd4, 8'd3, 1'b0},  // R2 one short
    '{7'd3,  5'd6,  10'd4, 8'd4, 1'b1},  // R2 exact
    '{7'd61, 5'd6,  10'd4, 8'd4, 1'b0},  // R1 lead, first edge misses
    '{7'd61, 5'd6,  10'd4, 8'd5, 1'b1},  // R1 lead
    '{7'd3,  5'd2,  10'd2, 8'd6, 1'b0},  // R1 outside window
    '{7'd0,  5'd0,  10'd1, 8'd1, 1'b1},  // R1 zero window coincident
    '{7'd1,  5'd0,  10'd1, 8'd5, 1'b0},  // R1 zero window, one tick off
    '{7'd5,  5'd5,  10'd0, 8'd1, 1'b1},  // R4 zero count, R1 inclusive
    '{7'd6,  5'd5,  10'd1, 8'd8, 1'b0},  // R1 one beyond limit
    '{7'd31, 5'd31, 10'd3, 8'd3, 1'b1},  // R1 widest window
    '{7'd58, 5'd6,  10'd3, 8'd4, 1'b1}   // R1 lead at limit
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, gateWaitEn = 1'b0, startGate = 1'b0;
  logic refIn = 1'b0, fbIn = 1'b0;
  logic [4:0] windowSet = 5'd6;
  logic [9:0] lockCount = 10'd1, unlockCount = 10'd1;
  logic locked;
  logic [1:0] phase;

  int t = 0, off = 3;
  logic fbOn = 1'b1;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_align_lock u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .gateWaitEn(gateWaitEn),
    .startGate(startGate), .refClkIn(refIn), .fbClkIn(fbIn),
    .windowSet(windowSet), .lockCount(lockCount), .unlockCount(unlockCount),
    .locked(locked), .phase(phase)
  );

  task automatic tick();
    @(negedge clk);
    refIn = (t % REF_P) < REF_P/2;
    fbIn  = fbOn && (t >= off) && (((t - off) % REF_P) < REF_P/2);
    t++;
  endtask

  task automatic runPeriods(int n);
    for (int i = 0; i < n * REF_P; i++) tick();
  endtask

  task automatic doReset();
    rstN = 1'b0; refIn = 1'b0; fbIn = 1'b0; t = 0; fbOn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8 reset state
    enable = 1'b1;
    @(negedge clk); #1;
    chk("R8 locked in reset", locked, 0);
    chk("R8 phase in reset", phase, 0);

    // Table of patterns
    for (int r = 0; r < 11; r++) begin
      enable = 1'b1; gateWaitEn = 1'b0; unlockCount = 10'd1;
      off = ROWS[r].off; windowSet = ROWS[r].win; lockCount = ROWS[r].lockC;
      doReset();
      runPeriods(ROWS[r].periods);
      chk($sformatf("R2 R1 row %0d locked", r), locked, ROWS[r].expLock);
      chk($sformatf("R7 row %0d phase", r), phase, ROWS[r].expLock ? 3 : 2);
    end

    // R5 disabled: aligned clocks never lock
    enable = 1'b0; off = 3; windowSet = 5'd6; lockCount = 10'd1;
    doReset();
    runPeriods(4);
    chk("R5 locked while disabled", locked, 0);
    chk("R5 phase while disabled", phase, 0);

    // R3 unlock hysteresis with feedback stopped
    enable = 1'b1; lockCount = 10'd2; unlockCount = 10'd3;
    doReset();
    runPeriods(2);
    chk("R2 locked before unlock test", locked, 1);
    fbOn = 1'b0; runPeriods(2);
    chk("R3 still locked after two misses", locked, 1);
    runPeriods(1);
    chk("R3 unlocked after three misses", locked, 0);
    chk("R3 phase back to acquire", phase, 2);

    // R3 an aligned sample restarts the miss run
    doReset();
    runPeriods(2);
    fbOn = 1'b0; runPeriods(2);
    fbOn = 1'b1; runPeriods(1);
    fbOn = 1'b0; runPeriods(2);
    chk("R3 miss run restarted", locked, 1);
    runPeriods(1);
    chk("R3 unlock after restarted run", locked, 0);

    // R4 unlock count zero
    lockCount = 10'd1; unlockCount = 10'd0;
    doReset();
    runPeriods(1);
    chk("R4 locked with count one", locked, 1);
    fbOn = 1'b0; runPeriods(1);
    chk("R4 single miss unlocks", locked, 0);

    // R5 enable drop while locked
    lockCount = 10'd2; unlockCount = 10'd1;
    doReset();
    runPeriods(2);
    chk("R5 locked before drop", locked, 1);
    enable = 1'b0; #1;
    chk("R5 locked falls with enable", locked, 0);
    runPeriods(1);
    chk("R5 phase idle when disabled", phase, 0);
    enable = 1'b1;
    runPeriods(1);
    chk("R5 count restarts after enable", locked, 0);
    runPeriods(1);
    chk("R5 relock after full count", locked, 1);

    // R6 start gate
    gateWaitEn = 1'b1; lockCount = 10'd2;
    doReset();
    runPeriods(4);
    chk("R6 held in gate phase", phase, 1);
    chk("R6 no lock while gated", locked, 0);
    startGate = 1'b1; runPeriods(1); startGate = 1'b0;
    chk("R6 acquire after gate", phase, 2);
    runPeriods(2);
    chk("R6 lock after gate", locked, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule